// File: doc/BRIEF.md
# Receive Control Word Parser

This block sits on the receive side of a 16-bit packet bus that carries in-band control words. A control word is marked by a separate control/data indicator. Every valid input word is classified as idle, training, start-of-packet control, continuation control, end-only control, malformed control or payload data. The block then emits one tag set per word for the buffer writer downstream. The tag set holds the port the word belongs to, the packet-boundary flags and a protocol-violation pulse.

Payload control words load a new port address, and the following data words inherit it. End-of-packet status rides in the next control word, so that status is reported together with the port of the packet it closes. Start-of-packet control words must keep a minimum spacing, and a start word that comes too early is flagged. Continuation control words have no spacing rule, so several of them can arrive back to back, one per port. With `OUT_REG=1` (the default) every tag is registered, which gives one cycle of latency.

Top module: `ctl_word_parser`

## Requirements
- R1: During reset and in the first cycle after it, `o_valid`, `o_viol` and all flags are 0 and `o_port` is 0. Reset also clears the start-spacing history, so the first start word after reset is never flagged.
- R2: Each cycle with `in_valid`=1 produces `o_valid`=1 exactly one cycle later. A cycle with `in_valid`=0 produces `o_valid`=0 with all flags 0, and it changes no state: neither the port nor the open-burst condition.
- R3: `o_kind` codes are 0 idle, 1 training, 2 start control, 3 continuation control, 4 data, 5 end-only control, 6 malformed. A control word with bit 15 set is code 2 when bit 12 is 1 and code 3 when bit 12 is 0. With bit 15 clear, the word is code 6 if bit 12 is set, code 5 if bits 14:13 are nonzero, code 1 if it equals 0x0FFF, and code 0 otherwise. A word with `in_ctl`=0 is code 4.
- R4: A control word with bit 15 set loads the port from bits 11:4 and raises `o_payload`. `o_port` shows the port in force after the word, so data words carry the port of the last payload control word.
- R5: Bits 14:13 of any control word give the status of the previous packet: 00 none, 01 abort, 10 end with 2 valid bytes, 11 end with 1 valid byte. A nonzero status raises `o_eop`. Status 01 also raises `o_abort`, and status 11 raises `o_one_byte`. `o_end_port` gives the port in force before the word.
- R6: `o_sop` is 1 only on the first data word after a start control word.
- R7: A start control word that arrives fewer than `MIN_SOP_GAP` (8) clock cycles after the previous valid start control word raises `o_viol` for that word. The word is still fully decoded. A gap of exactly 8 cycles is legal, and cycles without a valid word count toward the gap.
- R8: Continuation control words never raise `o_viol`, even when they come back to back. Each one switches to its own port.
- R9: A data word raises `o_viol` when no burst is open. A burst is opened by a payload control word (code 2 or 3) and closed by any other control word.
- R10: A malformed control word (bit 15 clear, bit 12 set) raises `o_viol` and closes the open burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_ctl | input | 1 | 1 = control word, 0 = data word |
| in_word | input | 16 | Bus word |
| o_valid | output | 1 | Tag set valid |
| o_kind | output | 3 | Word class code (R3) |
| o_port | output | 8 | Port in force after the word |
| o_sop | output | 1 | First data word of a packet |
| o_eop | output | 1 | Previous packet ends at this control word |
| o_abort | output | 1 | Previous packet ended in error |
| o_one_byte | output | 1 | Last word of previous packet holds one valid byte |
| o_end_port | output | 8 | Port of the packet being closed |
| o_payload | output | 1 | Payload follows this control word |
| o_viol | output | 1 | Protocol violation pulse |

## Verification
The bench sends start words exactly 8, 7 and 6 cycles apart. A spacing counter that is off by one either flags a legal 8-cycle gap or lets a 7-cycle gap pass. A run of continuation words for different ports with no data between them shows whether the end port is taken from the previous port or from the new one. The bench also checks that such a run raises no violation, which catches spacing logic applied to every payload word instead of only start words. Invalid cycles sit between control words to prove that they neither close a burst nor stall the spacing count, and a reset mid-run proves that the spacing history is cleared.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

   typedef enum logic [2:0] {
      KIND_IDLE  = 3'd0,
      KIND_TRAIN = 3'd1,
      KIND_SOPW  = 3'd2,
      KIND_CONTW = 3'd3,
      KIND_DATA  = 3'd4,
      KIND_ENDW  = 3'd5,
      KIND_BAD   = 3'd6
   } kind_e;

   typedef enum logic [1:0] {
      ST_NONE  = 2'd0,
      ST_ABORT = 2'd1,
      ST_EOP2  = 2'd2,
      ST_EOP1  = 2'd3
   } end_st_e;

endpackage

// File: rtl/ctlp_decode.sv
module ctlp_decode
   import ctlp_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int PORT_W   = 8,
   parameter int PORT_LSB = 4
) (
   input  logic [WORD_W-1:0] word,
   input  logic              is_ctl,
   output kind_e             kind,
   output end_st_e           status,
   output logic [PORT_W-1:0] new_port
);
   localparam int PAY_BIT = WORD_W - 1;
   localparam int ST_HI   = WORD_W - 2;
   localparam int ST_LO   = WORD_W - 3;
   localparam int SOP_BIT = WORD_W - 4;
   localparam int LOW_W   = WORD_W - 4;

   logic pay_bit, sop_bit, low_ones;
   logic [1:0] st_raw;

   always_comb begin
      pay_bit  = word[PAY_BIT];
      sop_bit  = word[SOP_BIT];
      st_raw   = word[ST_HI:ST_LO];
      low_ones = &word[LOW_W-1:0];
      status   = end_st_e'(st_raw);
      new_port = word[PORT_LSB +: PORT_W];
      if (!is_ctl)                kind = KIND_DATA;
      else if (pay_bit)           kind = sop_bit ? KIND_SOPW : KIND_CONTW;
      else if (sop_bit)           kind = KIND_BAD;
      else if (st_raw != 2'b00)   kind = KIND_ENDW;
      else if (low_ones)          kind = KIND_TRAIN;
      else                        kind = KIND_IDLE;
   end

endmodule

// File: rtl/ctlp_sop_gap.sv
module ctlp_sop_gap #(
   parameter int MIN_SOP_GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sop_now,
   output logic too_close
);
   localparam int CNT_W = $clog2(MIN_SOP_GAP + 1);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_SOP_GAP);

   logic [CNT_W-1:0] dist_q;

   assign too_close = sop_now && (dist_q < SAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             dist_q <= SAT;
      else if (sop_now)       dist_q <= CNT_W'(1);
      else if (dist_q < SAT)  dist_q <= dist_q + CNT_W'(1);
   end

endmodule

// File: rtl/ctlp_track.sv
module ctlp_track
   import ctlp_pkg::*;
#(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  kind_e             kind,
   input  end_st_e           status,
   input  logic [PORT_W-1:0] new_port,
   input  logic              too_close,
   output logic              t_valid,
   output kind_e             t_kind,
   output logic [PORT_W-1:0] t_port,
   output logic              t_sop,
   output logic              t_eop,
   output logic              t_abort,
   output logic              t_one,
   output logic [PORT_W-1:0] t_end_port,
   output logic              t_payload,
   output logic              t_viol
);
   logic [PORT_W-1:0] port_q, port_d;
   logic open_q, open_d, pend_q, pend_d;
   logic is_pay, is_ctl;

   always_comb begin
      is_pay = (kind == KIND_SOPW) || (kind == KIND_CONTW);
      is_ctl = (kind != KIND_DATA);
      port_d = (valid && is_pay) ? new_port : port_q;
      open_d = open_q;
      pend_d = pend_q;
      if (valid) begin
         if (is_ctl) begin
            open_d = is_pay;
            pend_d = (kind == KIND_SOPW);
         end else begin
            pend_d = 1'b0;
         end
      end
      t_valid    = valid;
      t_kind     = valid ? kind : KIND_IDLE;
      t_port     = port_d;
      t_end_port = port_q;
      t_sop      = valid && !is_ctl && pend_q;
      t_eop      = valid && is_ctl && (status != ST_NONE);
      t_abort    = valid && is_ctl && (status == ST_ABORT);
      t_one      = valid && is_ctl && (status == ST_EOP1);
      t_payload  = valid && is_pay;
      t_viol     = valid && (((kind == KIND_SOPW) && too_close) ||
                             ((kind == KIND_DATA) && !open_q) ||
                             (kind == KIND_BAD));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '0;
         open_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         port_q <= port_d;
         open_q <= open_d;
         pend_q <= pend_d;
      end
   end

endmodule

// File: rtl/ctl_word_parser.sv
module ctl_word_parser
   import ctlp_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int PORT_W      = 8,
   parameter int PORT_LSB    = 4,
   parameter int MIN_SOP_GAP = 8,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ctl,
   input  logic [WORD_W-1:0] in_word,
   output logic              o_valid,
   output logic [2:0]        o_kind,
   output logic [PORT_W-1:0] o_port,
   output logic              o_sop,
   output logic              o_eop,
   output logic              o_abort,
   output logic              o_one_byte,
   output logic [PORT_W-1:0] o_end_port,
   output logic              o_payload,
   output logic              o_viol
);
   if (WORD_W < 8) begin : g_chk_word
      $error("WORD_W must be at least 8");
   end
   if (PORT_LSB + PORT_W > WORD_W - 4) begin : g_chk_port
      $error("port field overlaps the type bits");
   end
   if (MIN_SOP_GAP < 1) begin : g_chk_gap
      $error("MIN_SOP_GAP must be at least 1");
   end

   kind_e             dec_kind, t_kind;
   end_st_e           dec_st;
   logic [PORT_W-1:0] dec_port, t_port, t_end_port;
   logic              too_close, t_valid, t_sop, t_eop, t_abort, t_one, t_payload, t_viol;

   ctlp_decode #(.WORD_W(WORD_W), .PORT_W(PORT_W), .PORT_LSB(PORT_LSB)) i_decode (
      .word(in_word), .is_ctl(in_ctl), .kind(dec_kind), .status(dec_st), .new_port(dec_port)
   );

   ctlp_sop_gap #(.MIN_SOP_GAP(MIN_SOP_GAP)) i_gap (
      .clk(clk), .rst_n(rst_n),
      .sop_now(in_valid && (dec_kind == KIND_SOPW)),
      .too_close(too_close)
   );

   ctlp_track #(.PORT_W(PORT_W)) i_track (
      .clk(clk), .rst_n(rst_n), .valid(in_valid), .kind(dec_kind), .status(dec_st),
      .new_port(dec_port), .too_close(too_close),
      .t_valid(t_valid), .t_kind(t_kind), .t_port(t_port), .t_sop(t_sop), .t_eop(t_eop),
      .t_abort(t_abort), .t_one(t_one), .t_end_port(t_end_port), .t_payload(t_payload),
      .t_viol(t_viol)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            o_valid    <= 1'b0;
            o_kind     <= 3'd0;
            o_port     <= '0;
            o_sop      <= 1'b0;
            o_eop      <= 1'b0;
            o_abort    <= 1'b0;
            o_one_byte <= 1'b0;
            o_end_port <= '0;
            o_payload  <= 1'b0;
            o_viol     <= 1'b0;
         end else begin
            o_valid    <= t_valid;
            o_kind     <= t_kind;
            o_port     <= t_port;
            o_sop      <= t_sop;
            o_eop      <= t_eop;
            o_abort    <= t_abort;
            o_one_byte <= t_one;
            o_end_port <= t_end_port;
            o_payload  <= t_payload;
            o_viol     <= t_viol;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         o_valid    = t_valid;
         o_kind     = t_kind;
         o_port     = t_port;
         o_sop      = t_sop;
         o_eop      = t_eop;
         o_abort    = t_abort;
         o_one_byte = t_one;
         o_end_port = t_end_port;
         o_payload  = t_payload;
         o_viol     = t_viol;
      end
   end

endmodule

// File: rtl/ctlp_chk.sv
module ctlp_chk
   import ctlp_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int PORT_W   = 8,
   parameter int PORT_LSB = 4,
   parameter bit OUT_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ctl,
   input logic [WORD_W-1:0] in_word,
   input logic              o_valid,
   input logic [2:0]        o_kind,
   input logic [PORT_W-1:0] o_port,
   input logic              o_sop,
   input logic              o_eop,
   input logic              o_abort,
   input logic              o_one_byte,
   input logic              o_payload,
   input logic              o_viol
);
   logic sop_in, cont_in, bad_in;
   assign sop_in  = in_valid && in_ctl && in_word[WORD_W-1] && in_word[WORD_W-4];
   assign cont_in = in_valid && in_ctl && in_word[WORD_W-1] && !in_word[WORD_W-4];
   assign bad_in  = in_valid && in_ctl && !in_word[WORD_W-1] && in_word[WORD_W-4];

   if (OUT_REG) begin : g_props
      // R2
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> o_valid);
      // R2
      quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !o_valid |-> !(o_sop || o_eop || o_payload || o_viol));
      // R5
      abort_is_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (o_abort || o_one_byte) |-> (o_eop && !(o_abort && o_one_byte)));
      // R6
      sop_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         o_sop |-> (o_kind == 3'(KIND_DATA)));
      // R4
      port_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ctl && in_word[WORD_W-1]) |=>
            (o_port == $past(in_word[PORT_LSB +: PORT_W]) && o_payload));
      // R8
      cont_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cont_in |=> !o_viol);
      // R7
      sop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sop_in && $past(sop_in) && $past(rst_n)) |=> o_viol);
      // R10
      bad_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bad_in |=> (o_viol && o_kind == 3'(KIND_BAD)));
   end

endmodule

bind ctl_word_parser ctlp_chk #(
   .WORD_W(WORD_W), .PORT_W(PORT_W), .PORT_LSB(PORT_LSB), .OUT_REG(OUT_REG)
) i_ctlp_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl), .in_word(in_word),
   .o_valid(o_valid), .o_kind(o_kind), .o_port(o_port), .o_sop(o_sop), .o_eop(o_eop),
   .o_abort(o_abort), .o_one_byte(o_one_byte), .o_payload(o_payload), .o_viol(o_viol)
);

// File: tb/test_ctl_word_parser.sv
`timescale 1ns/1ps
module test_ctl_word_parser;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_ctl = 1'b0;
   logic [15:0] in_word = 16'h0;
   logic o_valid, o_sop, o_eop, o_abort, o_one_byte, o_payload, o_viol;
   logic [2:0] o_kind;
   logic [7:0] o_port, o_end_port;
   int runs = 0, fails = 0;

   always #2.5 clk = ~clk;

   ctl_word_parser i_ctl_word_parser (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl), .in_word(in_word),
      .o_valid(o_valid), .o_kind(o_kind), .o_port(o_port), .o_sop(o_sop), .o_eop(o_eop),
      .o_abort(o_abort), .o_one_byte(o_one_byte), .o_end_port(o_end_port),
      .o_payload(o_payload), .o_viol(o_viol)
   );

   typedef struct packed {
      logic        c;
      logic [15:0] w;
      logic [2:0]  k;
      logic [7:0]  p;
      logic        s, e, a, o;
      logic [7:0]  ep;
      logic        pl, v;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{1'b1,16'h000F,3'd0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0},
      '{1'b1,16'h0FFF,3'd1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0},
      '{1'b1,16'h9050,3'd2,8'h05,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b0},
      '{1'b0,16'hA1A1,3'd4,8'h05,1'b1,1'b0,1'b0,1'b0,8'h05,1'b0,1'b0},
      '{1'b0,16'hB2B2,3'd4,8'h05,1'b0,1'b0,1'b0,1'b0,8'h05,1'b0,1'b0},
      '{1'b1,16'hC070,3'd3,8'h07,1'b0,1'b1,1'b0,1'b0,8'h05,1'b1,1'b0},
      '{1'b0,16'hC3C3,3'd4,8'h07,1'b0,1'b0,1'b0,1'b0,8'h07,1'b0,1'b0},
      '{1'b1,16'hE090,3'd3,8'h09,1'b0,1'b1,1'b0,1'b1,8'h07,1'b1,1'b0},
      '{1'b1,16'h80A0,3'd3,8'h0A,1'b0,1'b0,1'b0,1'b0,8'h09,1'b1,1'b0},
      '{1'b0,16'hD4D4,3'd4,8'h0A,1'b0,1'b0,1'b0,1'b0,8'h0A,1'b0,1'b0},
      '{1'b1,16'hD210,3'd2,8'h21,1'b0,1'b1,1'b0,1'b0,8'h0A,1'b1,1'b0},
      '{1'b0,16'hE5E5,3'd4,8'h21,1'b1,1'b0,1'b0,1'b0,8'h21,1'b0,1'b0},
      '{1'b1,16'hB330,3'd2,8'h33,1'b0,1'b1,1'b1,1'b0,8'h21,1'b1,1'b1},
      '{1'b0,16'hF6F6,3'd4,8'h33,1'b1,1'b0,1'b0,1'b0,8'h33,1'b0,1'b0},
      '{1'b1,16'h2000,3'd5,8'h33,1'b0,1'b1,1'b1,1'b0,8'h33,1'b0,1'b0},
      '{1'b0,16'h1234,3'd4,8'h33,1'b0,1'b0,1'b0,1'b0,8'h33,1'b0,1'b1},
      '{1'b1,16'h1000,3'd6,8'h33,1'b0,1'b0,1'b0,1'b0,8'h33,1'b0,1'b1},
      '{1'b1,16'h4000,3'd5,8'h33,1'b0,1'b1,1'b0,1'b0,8'h33,1'b0,1'b0},
      '{1'b1,16'h9FF0,3'd2,8'hFF,1'b0,1'b0,1'b0,1'b0,8'h33,1'b1,1'b1},
      '{1'b0,16'h0101,3'd4,8'hFF,1'b1,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0},
      '{1'b0,16'h0202,3'd4,8'hFF,1'b0,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0},
      '{1'b0,16'h0303,3'd4,8'hFF,1'b0,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0},
      '{1'b0,16'h0404,3'd4,8'hFF,1'b0,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0},
      '{1'b0,16'h0505,3'd4,8'hFF,1'b0,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0},
      '{1'b0,16'h0606,3'd4,8'hFF,1'b0,1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0},
      '{1'b1,16'h9420,3'd2,8'h42,1'b0,1'b0,1'b0,1'b0,8'hFF,1'b1,1'b1},
      '{1'b0,16'h0707,3'd4,8'h42,1'b1,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b0,16'h0808,3'd4,8'h42,1'b0,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b0,16'h0909,3'd4,8'h42,1'b0,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b0,16'h0A0A,3'd4,8'h42,1'b0,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b0,16'h0B0B,3'd4,8'h42,1'b0,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b0,16'h0C0C,3'd4,8'h42,1'b0,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b0,16'h0D0D,3'd4,8'h42,1'b0,1'b0,1'b0,1'b0,8'h42,1'b0,1'b0},
      '{1'b1,16'hF430,3'd2,8'h43,1'b0,1'b1,1'b0,1'b1,8'h42,1'b1,1'b0},
      '{1'b0,16'h0E0E,3'd4,8'h43,1'b1,1'b0,1'b0,1'b0,8'h43,1'b0,1'b0},
      '{1'b1,16'h000F,3'd0,8'h43,1'b0,1'b0,1'b0,1'b0,8'h43,1'b0,1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_vec(input int idx);
      vec_t x;
      x = VEC[idx];
      check($sformatf("R2 valid #%0d", idx), 32'(o_valid), 32'(1));
      check($sformatf("R3 kind #%0d", idx), 32'(o_kind), 32'(x.k));
      check($sformatf("R4 port #%0d", idx), 32'(o_port), 32'(x.p));
      check($sformatf("R4 payload #%0d", idx), 32'(o_payload), 32'(x.pl));
      check($sformatf("R6 sop #%0d", idx), 32'(o_sop), 32'(x.s));
      check($sformatf("R5 eop/abort/one #%0d", idx),
            32'({o_eop, o_abort, o_one_byte}), 32'({x.e, x.a, x.o}));
      check($sformatf("R5 end port #%0d", idx), 32'(o_end_port), 32'(x.ep));
      check($sformatf("R7 R8 R9 R10 viol #%0d", idx), 32'(o_viol), 32'(x.v));
   endtask

   task automatic drive(input logic v, input logic c, input logic [15:0] w);
      in_valid = v;
      in_ctl   = c;
      in_word  = w;
   endtask

   initial begin : watchdog
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      check("R1 valid in reset", 32'(o_valid), 32'(0));
      check("R1 port in reset", 32'(o_port), 32'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 viol after reset", 32'(o_viol), 32'(0));
      check("R1 valid after reset", 32'(o_valid), 32'(0));

      for (int i = 0; i <= NV; i++) begin
         if (i > 0) check_vec(i - 1);
         if (i < NV) drive(1'b1, VEC[i].c, VEC[i].w);
         else        drive(1'b0, 1'b0, 16'h0);
         @(negedge clk);
      end

      // R2: invalid cycle neither closes the burst nor changes the port
      drive(1'b1, 1'b1, 16'h8500);
      @(negedge clk);
      check("R4 cont port", 32'(o_port), 32'(8'h50));
      check("R8 cont no viol", 32'(o_viol), 32'(0));
      drive(1'b0, 1'b1, 16'h000F);
      @(negedge clk);
      check("R2 no valid", 32'(o_valid), 32'(0));
      check("R2 quiet flags", 32'({o_payload, o_eop, o_viol}), 32'(0));
      drive(1'b1, 1'b0, 16'h5555);
      @(negedge clk);
      check("R2 port kept", 32'(o_port), 32'(8'h50));
      check("R2 R9 burst still open", 32'(o_viol), 32'(0));
      drive(1'b0, 1'b0, 16'h0);
      repeat (10) @(negedge clk);

      // R7: gap counted in clock cycles including idle ones
      drive(1'b1, 1'b1, 16'h9600);
      @(negedge clk);
      check("R7 first sop", 32'(o_viol), 32'(0));
      drive(1'b0, 1'b0, 16'h0);
      repeat (7) @(negedge clk);
      drive(1'b1, 1'b1, 16'h9610);
      @(negedge clk);
      check("R7 gap 8 legal", 32'(o_viol), 32'(0));
      check("R7 port", 32'(o_port), 32'(8'h61));
      drive(1'b0, 1'b0, 16'h0);
      repeat (6) @(negedge clk);
      drive(1'b1, 1'b1, 16'h9620);
      @(negedge clk);
      check("R7 gap 7 flagged", 32'(o_viol), 32'(1));
      check("R7 still decoded", 32'(o_port), 32'(8'h62));

      // R1: reset mid-run clears port and spacing history
      drive(1'b1, 1'b1, 16'h9700);
      @(negedge clk);
      drive(1'b0, 1'b0, 16'h0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 port after mid reset", 32'(o_port), 32'(0));
      check("R1 valid after mid reset", 32'(o_valid), 32'(0));
      rst_n = 1'b1;
      drive(1'b1, 1'b1, 16'h9710);
      @(negedge clk);
      check("R1 no spacing history", 32'(o_viol), 32'(0));
      check("R1 end port cleared", 32'(o_end_port), 32'(0));
      drive(1'b0, 1'b0, 16'h0);
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

endmodule